// File: doc/BRIEF.md
# PLL Lock Detector

This block decides whether a fractional-N synthesizer loop has settled. It watches the two pulse trains that feed the tri-state phase comparator: the divided reference and the divided feedback from the main divider. For each pair of rising edges it counts how many cycles of a fast sampling clock separate them. Either input may arrive first. A pair whose separation is under a small window counts as an in-window comparison.

A run counter tracks consecutive in-window comparisons. The lock flag comes up once the run reaches its target length. Any comparison outside the window clears the run and the flag. The flag is meant to be read as a status bit by a serial register interface. That interface, the charge pump and the loop filter are not part of this block.

Both pulse inputs are brought into the sampling clock domain through synchronizer chains of equal depth, so the chains add the same delay to each input. The window defaults to 4 sampling cycles, which is about 5 ns at a sampling clock near 800 MHz. The run target defaults to 16.

Top module: `pll_lock_monitor`

## Requirements
- R1: A rising edge on either pulse input starts a comparison. The next rising edge on the other input ends it and produces one strobe on `cmp_valid_o`, one cycle wide. The strobe does not depend on which input led.
- R2: The offset is the number of sampling cycles between the two synchronized rising edges. A comparison is in window (`cmp_hit_o` = 1 with the strobe) when the offset is less than `WIN_CYCLES` (default 4). Edges seen in the same cycle give offset 0. With the default, offsets of 3 are hits and offsets of 4 or more are misses.
- R3: A second rising edge on the input that started the comparison, before the other input has produced one, ends that comparison as out of window (`cmp_hit_o` = 0). That repeated edge then starts a fresh comparison.
- R4: Each in-window comparison adds one to the run. `lock_o` goes to 1 in the cycle after the strobe of the `RUN_LEN`-th (default 16) consecutive in-window comparison, and not before.
- R5: An out-of-window comparison returns the run to zero and drops `lock_o` in the cycle after its strobe. After that, a full `RUN_LEN` in-window comparisons are needed again.
- R6: Further in-window comparisons after lock keep `lock_o` at 1, because the run saturates at `RUN_LEN`.
- R7: Synchronous active-high `rst` clears the run and `lock_o` and returns the measurement to idle, with no strobe pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_pulse_i | input | 1 | Reference divider output pulse |
| fb_pulse_i | input | 1 | Main (feedback) divider output pulse |
| cmp_valid_o | output | 1 | One-cycle strobe at the end of each comparison |
| cmp_hit_o | output | 1 | In-window result, qualified by `cmp_valid_o` |
| lock_o | output | 1 | Lock status flag |

## Verification
The main stimulus is a table of signed edge offsets. These include zero, small leads and lags in both directions, the last offset inside the window (3) and the first one outside it (4). Together they show that the window is measured without regard to which input leads and that the boundary sits exactly at `WIN_CYCLES`.

The order of entries in the table checks the run counter. Exactly 16 hits must lock. A miss after lock must drop the flag. A run of 15 hits after a miss must not lock, and extra hits must hold the flag. Directed cases then send a doubled edge on each input in turn, to tell a repeated-edge miss apart from a real pairing. A final case checks that reset clears a held lock.

// File: rtl/plld_pkg.sv
package plld_pkg;

    // Measurement state: idle, or waiting for the lagging input
    typedef enum logic [1:0] {
        MS_IDLE     = 2'd0,
        MS_WAIT_FB  = 2'd1,
        MS_WAIT_REF = 2'd2
    } meter_state_t;

    // Synchronized rising-edge events, one per input
    typedef struct packed {
        logic ref_rise;
        logic fb_rise;
    } edge_pair_t;

    // Result of one comparison
    typedef struct packed {
        logic valid;
        logic hit;
    } cmp_result_t;

    localparam int unsigned CH_REF = 0;
    localparam int unsigned CH_FB  = 1;
    localparam int unsigned N_CH   = 2;

    localparam cmp_result_t NO_RESULT = '{valid: 1'b0, hit: 1'b0};

    function automatic cmp_result_t make_result(input logic hit);
        cmp_result_t r;
        r.valid = 1'b1;
        r.hit   = hit;
        return r;
    endfunction

endpackage

// File: rtl/plld_edge_sync.sv
module plld_edge_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic rise
);
    // pipe[STAGES-1:0] is the synchronizer chain; pipe[STAGES] holds the prior value
    localparam int unsigned PW = STAGES + 1;

    logic [PW-1:0] pipe;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[PW-2:0], din};
        end
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];

    // An edge event lasts exactly one cycle
    assert_rise_single_R1: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/plld_phase_meter.sv
module plld_phase_meter
    import plld_pkg::*;
#(
    parameter int unsigned WIN_CYCLES = 4,
    parameter int unsigned OFS_W      = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  edge_pair_t  edges,
    output cmp_result_t result
);
    localparam logic [OFS_W-1:0] OFS_MAX = {OFS_W{1'b1}};
    localparam logic [OFS_W-1:0] OFS_ONE = {{(OFS_W-1){1'b0}}, 1'b1};

    meter_state_t     state_q, state_d;
    logic [OFS_W-1:0] cnt_q, cnt_d;
    cmp_result_t      res_q, res_d;
    logic             in_win;

    assign in_win = (int'(cnt_q) < int'(WIN_CYCLES));

    always_comb begin
        state_d = state_q;
        cnt_d   = (cnt_q == OFS_MAX) ? cnt_q : cnt_q + OFS_ONE;
        res_d   = NO_RESULT;
        unique case (state_q)
            MS_IDLE: begin
                if (edges.ref_rise && edges.fb_rise) begin
                    res_d = make_result(WIN_CYCLES > 0);
                end else if (edges.ref_rise) begin
                    state_d = MS_WAIT_FB;
                    cnt_d   = OFS_ONE;
                end else if (edges.fb_rise) begin
                    state_d = MS_WAIT_REF;
                    cnt_d   = OFS_ONE;
                end
            end
            MS_WAIT_FB: begin
                if (edges.ref_rise) begin
                    res_d = make_result(1'b0);
                    if (edges.fb_rise) begin
                        state_d = MS_IDLE;
                    end else begin
                        cnt_d = OFS_ONE;
                    end
                end else if (edges.fb_rise) begin
                    res_d   = make_result(in_win);
                    state_d = MS_IDLE;
                end
            end
            MS_WAIT_REF: begin
                if (edges.fb_rise) begin
                    res_d = make_result(1'b0);
                    if (edges.ref_rise) begin
                        state_d = MS_IDLE;
                    end else begin
                        cnt_d = OFS_ONE;
                    end
                end else if (edges.ref_rise) begin
                    res_d   = make_result(in_win);
                    state_d = MS_IDLE;
                end
            end
            default: begin
                state_d = MS_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= MS_IDLE;
            cnt_q   <= '0;
            res_q   <= NO_RESULT;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            res_q   <= res_d;
        end
    end

    assign result = res_q;

    // A repeated leading edge always yields an out-of-window result
    assert_repeat_ref_miss_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == MS_WAIT_FB && edges.ref_rise) |=> (result.valid && !result.hit));
    assert_repeat_fb_miss_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == MS_WAIT_REF && edges.fb_rise) |=> (result.valid && !result.hit));

    // Coincident edges from idle give an in-window result
    assert_coincident_hit_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == MS_IDLE && edges.ref_rise && edges.fb_rise) |=> (result.valid && result.hit));

    // No strobe while idle and no edge arrives
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
        (!edges.ref_rise && !edges.fb_rise) |=> !result.valid);

    // Reset leaves no pending strobe
    assert_reset_idle_R7: assert property (@(posedge clk)
        rst |=> (!result.valid && state_q == MS_IDLE));

endmodule

// File: rtl/plld_run_tracker.sv
module plld_run_tracker
    import plld_pkg::*;
#(
    parameter int unsigned RUN_LEN = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  cmp_result_t result,
    output logic        lock
);
    localparam int unsigned    RUN_W = $clog2(RUN_LEN + 1);
    localparam logic [RUN_W-1:0] RUN_TOP = RUN_W'(RUN_LEN);

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
        end else if (result.valid) begin
            if (!result.hit) begin
                run_q <= '0;
            end else if (run_q != RUN_TOP) begin
                run_q <= run_q + 1'b1;
            end
        end
    end

    assign lock = (run_q == RUN_TOP);

    assert_run_bound_R6: assert property (@(posedge clk) disable iff (rst)
        run_q <= RUN_TOP);

    assert_miss_clears_R5: assert property (@(posedge clk) disable iff (rst)
        (result.valid && !result.hit) |=> (run_q == '0 && !lock));

    assert_hit_counts_R4: assert property (@(posedge clk) disable iff (rst)
        (result.valid && result.hit && run_q != RUN_TOP) |=> (run_q == $past(run_q) + 1'b1));

    assert_lock_after_hit_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(lock) |-> $past(result.valid && result.hit));

    assert_lock_holds_R6: assert property (@(posedge clk) disable iff (rst)
        (lock && !(result.valid && !result.hit)) |=> lock);

    assert_reset_clears_R7: assert property (@(posedge clk)
        rst |=> (run_q == '0 && !lock));

endmodule

// File: rtl/pll_lock_monitor.sv
module pll_lock_monitor
    import plld_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned WIN_CYCLES  = 4,
    parameter int unsigned OFS_W       = 8,
    parameter int unsigned RUN_LEN     = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_pulse_i,
    input  logic fb_pulse_i,
    output logic cmp_valid_o,
    output logic cmp_hit_o,
    output logic lock_o
);
    logic [N_CH-1:0] raw;
    logic [N_CH-1:0] rise;
    edge_pair_t      edges;
    cmp_result_t     result;

    assign raw[CH_REF] = ref_pulse_i;
    assign raw[CH_FB]  = fb_pulse_i;

    // Equal synchronizer depth on both inputs keeps the measured offset intact
    for (genvar ch = 0; ch < N_CH; ch++) begin : g_sync
        plld_edge_sync #(
            .STAGES (SYNC_STAGES)
        ) i_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw[ch]),
            .rise (rise[ch])
        );
    end

    assign edges.ref_rise = rise[CH_REF];
    assign edges.fb_rise  = rise[CH_FB];

    plld_phase_meter #(
        .WIN_CYCLES (WIN_CYCLES),
        .OFS_W      (OFS_W)
    ) i_meter (
        .clk    (clk),
        .rst    (rst),
        .edges  (edges),
        .result (result)
    );

    plld_run_tracker #(
        .RUN_LEN (RUN_LEN)
    ) i_tracker (
        .clk    (clk),
        .rst    (rst),
        .result (result),
        .lock   (lock_o)
    );

    assign cmp_valid_o = result.valid;
    assign cmp_hit_o   = result.hit;

    // Hit is only meaningful with the strobe
    assert_hit_qualified_R1: assert property (@(posedge clk) disable iff (rst)
        cmp_hit_o |-> cmp_valid_o);

endmodule

// File: tb/test_pll_lock_monitor.sv
module test_pll_lock_monitor;

    localparam int WIN   = 4;
    localparam int RUN   = 16;
    localparam int NVEC  = 40;

    // Signed offset: positive means feedback lags reference
    localparam int VEC_D [NVEC] = '{
        0, 1, -1, 2, -2, 3, -3, 0, 1, 2, 3, -1, -2, -3, 0, 1,
        2, -3, 4,
        0, 1, 2, 3, -1, -2, -3, 0, 1, 2, 3, -1, -2, -3, 0,
        -4, 7,
        3, 0, 0, 0
    };
    localparam bit VEC_HIT [NVEC] = '{
        1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1,
        1, 1, 0,
        1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1,
        0, 0,
        1, 1, 1, 1
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_p = 1'b0;
    logic fb_p = 1'b0;
    logic cmp_valid, cmp_hit, lock;

    int n_checks = 0;
    int n_fail = 0;
    int n_valid = 0;
    int n_miss = 0;
    bit last_hit = 1'b0;
    bit done = 1'b0;
    int model_run = 0;

    always #4 clk = ~clk;

    pll_lock_monitor #(
        .SYNC_STAGES (2),
        .WIN_CYCLES  (WIN),
        .OFS_W       (8),
        .RUN_LEN     (RUN)
    ) i_pll_lock_monitor (
        .clk         (clk),
        .rst         (rst),
        .ref_pulse_i (ref_p),
        .fb_pulse_i  (fb_p),
        .cmp_valid_o (cmp_valid),
        .cmp_hit_o   (cmp_hit),
        .lock_o      (lock)
    );

    always @(negedge clk) begin
        if (!rst && cmp_valid) begin
            n_valid  <= n_valid + 1;
            last_hit <= cmp_hit;
            if (!cmp_hit) n_miss <= n_miss + 1;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    // Drive one bit per negedge from each mask, then idle long enough to settle
    task automatic drive_wave(input logic [15:0] rw, input logic [15:0] fw);
        for (int t = 0; t < 16; t++) begin
            @(negedge clk);
            ref_p = rw[t];
            fb_p  = fw[t];
        end
        for (int t = 0; t < 8; t++) begin
            @(negedge clk);
            ref_p = 1'b0;
            fb_p  = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic apply_offset(input int d);
        logic [15:0] rw, fw;
        int ar, af;
        ar = (d < 0) ? -d : 0;
        af = (d > 0) ? d : 0;
        rw = 16'h0003 << ar;
        fw = 16'h0003 << af;
        drive_wave(rw, fw);
    endtask

    function automatic void model_step(input bit hit);
        if (!hit) model_run = 0;
        else if (model_run < RUN) model_run++;
    endfunction

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        int v0, m0;
        repeat (4) @(negedge clk);
        // R7: reset state
        check("R7 reset lock", int'(lock), 0);
        check("R7 reset strobe", int'(cmp_valid), 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 idle after reset", int'(cmp_valid), 0);

        // Table walk: R1 strobe count, R2 window, R4/R5/R6 lock sequence
        for (int i = 0; i < NVEC; i++) begin
            v0 = n_valid;
            apply_offset(VEC_D[i]);
            model_step(VEC_HIT[i]);
            check("R1 one strobe per pair", n_valid - v0, 1);
            check("R2 window result", int'(last_hit), int'(VEC_HIT[i]));
            check("R4 R5 R6 lock", int'(lock), int'(model_run == RUN));
        end

        // R3: repeated reference edge before feedback -> miss, then new pair offset 1
        v0 = n_valid; m0 = n_miss;
        drive_wave(16'h0033, 16'h0060);
        check("R3 two strobes", n_valid - v0, 2);
        check("R3 one miss", n_miss - m0, 1);
        check("R3 re-armed pair hit", int'(last_hit), 1);
        check("R5 lock dropped", int'(lock), 0);

        // R4: one hit already counted; 14 more must not lock, the 15th must
        for (int i = 0; i < 14; i++) apply_offset(i % 3);
        check("R4 no early lock", int'(lock), 0);
        apply_offset(-1);
        check("R4 lock at 16", int'(lock), 1);

        // R3 mirror: repeated feedback edge; R5 lock dropped
        v0 = n_valid; m0 = n_miss;
        drive_wave(16'h0060, 16'h0033);
        check("R3 fb repeat strobes", n_valid - v0, 2);
        check("R3 fb repeat miss", n_miss - m0, 1);
        check("R5 lock cleared by miss", int'(lock), 0);

        // R7: reset while locked
        for (int i = 0; i < RUN; i++) apply_offset(0);
        check("R6 locked before reset", int'(lock), 1);
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk);
        check("R7 reset clears lock", int'(lock), 0);
        rst = 1'b0;
        apply_offset(1);
        check("R7 run restarted", int'(lock), 0);
        check("R2 post-reset hit", int'(last_hit), 1);

        finish_run();
    end

    initial begin
        #(8 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule